// File: doc/BRIEF.md
# Configurable Serial Receiver with Stick Parity and Idle Timeout

This block recovers characters from an asynchronous serial line. The caller supplies an oversampling strobe, and one bit time lasts a fixed number of strobes. A 32-bit line-settings word selects the character shape: 5 to 8 data bits, one or two stop bits, and a parity mode. The parity mode is none, even, odd, or a fixed "stick" bit that is always 1 (mark) or always 0 (space). Each recovered character leaves on a one-cycle valid strobe. Framing errors, parity errors, line breaks and receive-idle timeouts are reported as one-cycle event pulses.

The same word can force the transmit line low to send a break, and it can turn the transmit line back into the receiver for loopback. Its upper half holds an idle timeout counted in bit times. The event pulses are collected in a write-one-to-clear status register. An enable mask selects which of those bits drive the interrupt output. Transmission framing, FIFOs and baud generation belong to neighbouring blocks.

Top module: `serial_rx_engine`

## Requirements
- R1: `line_cfg[1:0]` selects the character length: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8 data bits. Data arrives least significant bit first. `rx_data` carries the character with its unused upper bits zero, and `rx_valid` pulses for one cycle.
- R2: `line_cfg[2]` set means two stop bits are sampled. A low second stop bit raises `frame_err`.
- R3: `line_cfg[5:3]` selects parity: 000 none, 001 even, 011 odd, 101 mark (bit always 1), 111 space (bit always 0). A received parity bit that differs from the expected one pulses `parity_err` together with `rx_valid`.
- R4: A low stop bit in a frame that is not a break pulses `frame_err` together with `rx_valid`, and the character is still delivered.
- R5: A frame whose data bits, parity bit and first stop bit are all low pulses `break_det` alone, with no `rx_valid`, `frame_err` or `parity_err`. The receiver then waits for the line to return high before it looks for a new start bit.
- R6: A start bit is confirmed at mid-bit. A low pulse lasting OVERSAMPLE/2 samples or fewer is discarded and produces no output.
- R7: `line_cfg[6]` forces `txd_out` low, and otherwise `txd_out` follows `txd_in`. `line_cfg[7]` makes the receiver listen to `txd_out` instead of `rxd_in`.
- R8: `line_cfg[31:16]` = L > 0 gives an idle timeout of L bit times. If a received character stays unread (no `rd_ack`) for L bit times after it arrives, `rx_timeout` pulses once. Each new character restarts the count, `rd_ack` cancels it, and L = 0 disables it.
- R9: `irq_status` bits 10 (frame error), 11 (break), 12 (timeout) and 13 (parity error) are set by their events. All other bits read zero. Writing with `stat_wr` clears exactly the bits set in `stat_wdata`, and a new event wins over a clear in the same cycle.
- R10: `irq_out` is high exactly when some bit of `irq_status` is set and also enabled in `irq_mask`.
- R11: After reset `irq_status` is zero, `irq_out`, `rx_valid` and the event outputs are low, and `txd_out` follows `txd_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_tick | input | 1 | Oversampling strobe, OVERSAMPLE per bit |
| rxd_in | input | 1 | Serial receive line |
| txd_in | input | 1 | Transmit line from the transmitter |
| txd_out | output | 1 | Transmit line to the pin, break-forcing applied |
| line_cfg | input | 32 | Line-settings word |
| rd_ack | input | 1 | Pulse: the delivered character has been consumed |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 16 | Write-one-to-clear value |
| irq_mask | input | 16 | Interrupt enable mask |
| rx_data | output | 8 | Received character |
| rx_valid | output | 1 | Character strobe |
| frame_err | output | 1 | Framing error pulse |
| parity_err | output | 1 | Parity error pulse |
| break_det | output | 1 | Break pulse |
| rx_timeout | output | 1 | Idle timeout pulse |
| irq_status | output | 16 | Event status register |
| irq_out | output | 1 | Masked interrupt request |

## Verification
The main function is swept over every character length, both stop-bit counts and all five parity modes, using data patterns chosen to tell them apart. 0x55 and 0xA3 expose bit order and truncation, 0xFF gives all-ones parity, and 0x00 gives a zero character that must not be mistaken for a break. Deliberately wrong parity bits and low stop bits show that errors are flagged without losing the character. An all-low frame shows that a break is reported instead of a framing error. Short low glitches at and below half a bit test start qualification. The timeout is measured in cycles against L bit times, and it is also tried with a prompt acknowledge, a zero setting and back-to-back characters that restart it.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int CFG_W    = 32;
  localparam int STAT_W   = 16;
  localparam int MAX_BITS = 8;
  localparam int TMO_W    = 16;
  localparam int IRQ_FRM  = 10;
  localparam int IRQ_BRK  = 11;
  localparam int IRQ_TMO  = 12;
  localparam int IRQ_PAR  = 13;

  typedef enum logic [2:0] {
    PAR_NONE, PAR_EVEN, PAR_ODD, PAR_MARK, PAR_SPACE
  } par_kind_e;

  typedef struct packed {
    logic [TMO_W-1:0] tmo_bits;
    logic             loop_en;
    logic             force_brk;
    par_kind_e        par;
    logic             two_stop;
    logic [3:0]       nbits;
  } line_set_t;

  // parity field: bit0 enables, bits[2:1] pick even/odd/mark/space
  function automatic par_kind_e decode_par(input logic [2:0] f);
    if (!f[0]) return PAR_NONE;
    case (f[2:1])
      2'b00:   return PAR_EVEN;
      2'b01:   return PAR_ODD;
      2'b10:   return PAR_MARK;
      default: return PAR_SPACE;
    endcase
  endfunction

  function automatic logic [3:0] data_bits(input logic [1:0] f);
    return 4'd5 + {2'b00, f};
  endfunction

  function automatic line_set_t unpack_cfg(input logic [CFG_W-1:0] w);
    line_set_t s;
    s.tmo_bits  = w[31:16];
    s.loop_en   = w[7];
    s.force_brk = w[6];
    s.par       = decode_par(w[5:3]);
    s.two_stop  = w[2];
    s.nbits     = data_bits(w[1:0]);
    return s;
  endfunction

  // expected parity bit for an already-truncated character
  function automatic logic want_par(input par_kind_e k, input logic [MAX_BITS-1:0] d);
    case (k)
      PAR_EVEN:  return ^d;
      PAR_ODD:   return ~^d;
      PAR_MARK:  return 1'b1;
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int OS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                rx,
  input  logic [3:0]          nbits,
  input  logic                two_stop,
  input  par_kind_e           par,
  output logic [MAX_BITS-1:0] data,
  output logic                valid,
  output logic                ferr,
  output logic                perr,
  output logic                brk
);
  localparam int CW   = $clog2(OS);
  localparam int HALF = OS / 2;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD} st_e;

  st_e                 st;
  logic [CW-1:0]       cnt;
  logic [2:0]          idx;
  logic [MAX_BITS-1:0] shreg;
  logic                par_bit, all_zero, stop_sel, stop_bad;

  // named internal events
  logic mid_sample, par_on, last_data, finish, zero_now, bad_now;

  assign mid_sample = tick && (cnt == CW'(OS - 1)) &&
                      (st == S_DATA || st == S_PAR || st == S_STOP);
  assign par_on     = (par != PAR_NONE);
  assign last_data  = (idx == 3'(nbits - 4'd1));
  assign finish     = mid_sample && (st == S_STOP) && (stop_sel || !two_stop);
  assign zero_now   = stop_sel ? all_zero : (all_zero & ~rx);
  assign bad_now    = (stop_sel & stop_bad) | ~rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; idx <= '0; shreg <= '0; data <= '0;
      par_bit <= 1'b0; all_zero <= 1'b0; stop_sel <= 1'b0; stop_bad <= 1'b0;
      valid <= 1'b0; ferr <= 1'b0; perr <= 1'b0; brk <= 1'b0;
    end else begin
      valid <= 1'b0; ferr <= 1'b0; perr <= 1'b0; brk <= 1'b0;
      case (st)
        S_IDLE: if (tick && !rx) begin
          st  <= S_START;
          cnt <= '0;
        end
        S_START: if (tick) begin
          if (rx) st <= S_IDLE;
          else if (cnt == CW'(HALF - 1)) begin
            st <= S_DATA; cnt <= '0; idx <= '0;
            shreg <= '0; all_zero <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        S_DATA: if (tick) begin
          if (mid_sample) begin
            cnt <= '0;
            shreg[idx] <= rx;
            all_zero <= all_zero & ~rx;
            idx <= idx + 1'b1;
            stop_sel <= 1'b0;
            if (last_data) st <= par_on ? S_PAR : S_STOP;
          end else cnt <= cnt + 1'b1;
        end
        S_PAR: if (tick) begin
          if (mid_sample) begin
            cnt <= '0; par_bit <= rx;
            all_zero <= all_zero & ~rx;
            st <= S_STOP;
          end else cnt <= cnt + 1'b1;
        end
        S_STOP: if (tick) begin
          if (mid_sample) begin
            cnt <= '0;
            if (!finish) begin
              stop_sel <= 1'b1;
              stop_bad <= ~rx;
              all_zero <= all_zero & ~rx;
            end else begin
              if (zero_now) brk <= 1'b1;
              else begin
                valid <= 1'b1;
                data  <= shreg;
                ferr  <= bad_now;
                perr  <= par_on && (par_bit != want_par(par, shreg));
              end
              st <= rx ? S_IDLE : S_HOLD;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_HOLD: if (tick && rx) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_valid_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  assert_err_keeps_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ferr || perr) |-> valid);
  assert_brk_alone_R5: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !(valid || ferr || perr));
  assert_glitch_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_START && tick && rx) |=> (st == S_IDLE && !valid && !brk));
endmodule

// File: rtl/srx_timeout.sv
module srx_timeout
  import srx_pkg::*;
#(
  parameter int OS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             char_in,
  input  logic             rd_ack,
  input  logic [TMO_W-1:0] limit,
  output logic             tmo
);
  localparam int CW = $clog2(OS);

  logic [CW-1:0]    pre;
  logic [TMO_W-1:0] cnt;
  logic             armed, unread;
  logic             bit_end;

  assign bit_end = armed && tick && (pre == CW'(OS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0; cnt <= '0; armed <= 1'b0; unread <= 1'b0; tmo <= 1'b0;
    end else begin
      tmo <= 1'b0;
      if (char_in) begin
        pre <= '0; cnt <= '0;
        armed  <= (limit != '0);
        unread <= 1'b1;
      end else if (rd_ack) begin
        unread <= 1'b0;
        armed  <= 1'b0;
      end else if (armed && tick) begin
        if (bit_end) begin
          pre <= '0;
          if (cnt == limit - 1'b1) begin
            tmo   <= 1'b1;
            armed <= 1'b0;
          end else cnt <= cnt + 1'b1;
        end else pre <= pre + 1'b1;
      end
    end
  end

  assert_tmo_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> !tmo);
  assert_tmo_unread_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |-> $past(unread) && !$past(rd_ack) && !$past(char_in));
endmodule

// File: rtl/srx_irq.sv
module srx_irq
  import srx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_frm,
  input  logic              ev_brk,
  input  logic              ev_tmo,
  input  logic              ev_par,
  input  logic              wr,
  input  logic [STAT_W-1:0] wdata,
  input  logic [STAT_W-1:0] mask,
  output logic [STAT_W-1:0] stat,
  output logic              irq
);
  localparam logic [STAT_W-1:0] EV_MASK =
    STAT_W'((1 << IRQ_FRM) | (1 << IRQ_BRK) | (1 << IRQ_TMO) | (1 << IRQ_PAR));

  logic [STAT_W-1:0] set_vec, clr_vec;

  always_comb begin
    set_vec          = '0;
    set_vec[IRQ_FRM] = ev_frm;
    set_vec[IRQ_BRK] = ev_brk;
    set_vec[IRQ_TMO] = ev_tmo;
    set_vec[IRQ_PAR] = ev_par;
    clr_vec          = wr ? wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= ((stat & ~clr_vec) | set_vec) & EV_MASK;
  end

  assign irq = |(stat & mask);

  assert_spare_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat & ~EV_MASK) == '0);
  assert_frm_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frm |=> stat[IRQ_FRM]);
  assert_brk_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_brk |=> stat[IRQ_BRK]);

  for (genvar k = 0; k < STAT_W; k++) begin : g_sticky
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[k] && !(wr && wdata[k])) |=> stat[k]);
  end
endmodule

// File: rtl/serial_rx_engine.sv
module serial_rx_engine
  import srx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_tick,
  input  logic              rxd_in,
  input  logic              txd_in,
  output logic              txd_out,
  input  logic [CFG_W-1:0]  line_cfg,
  input  logic              rd_ack,
  input  logic              stat_wr,
  input  logic [STAT_W-1:0] stat_wdata,
  input  logic [STAT_W-1:0] irq_mask,
  output logic [7:0]        rx_data,
  output logic              rx_valid,
  output logic              frame_err,
  output logic              parity_err,
  output logic              break_det,
  output logic              rx_timeout,
  output logic [STAT_W-1:0] irq_status,
  output logic              irq_out
);
  line_set_t cfg;
  logic      rx_src, rx_s;

  assign cfg     = unpack_cfg(line_cfg);
  assign txd_out = cfg.force_brk ? 1'b0 : txd_in;
  assign rx_src  = cfg.loop_en ? txd_out : rxd_in;

  srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_src), .q(rx_s)
  );

  srx_frame #(.OS(OVERSAMPLE)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .rx(rx_s),
    .nbits(cfg.nbits), .two_stop(cfg.two_stop), .par(cfg.par),
    .data(rx_data), .valid(rx_valid), .ferr(frame_err),
    .perr(parity_err), .brk(break_det)
  );

  srx_timeout #(.OS(OVERSAMPLE)) u_tmo (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .char_in(rx_valid),
    .rd_ack(rd_ack), .limit(cfg.tmo_bits), .tmo(rx_timeout)
  );

  srx_irq u_irq (
    .clk(clk), .rst_n(rst_n), .ev_frm(frame_err), .ev_brk(break_det),
    .ev_tmo(rx_timeout), .ev_par(parity_err), .wr(stat_wr),
    .wdata(stat_wdata), .mask(irq_mask), .stat(irq_status), .irq(irq_out)
  );

  assert_force_break_R7: assert property (@(posedge clk) disable iff (!rst_n)
    line_cfg[6] |-> !txd_out);
endmodule

// File: tb/test_serial_rx_engine.sv
module test_serial_rx_engine;
  localparam int CLK_PERIOD = 10;
  localparam int OS = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_tick = 1'b1;
  logic        rxd_in = 1'b1;
  logic        txd_in = 1'b1;
  logic        txd_out;
  logic [31:0] line_cfg = 32'h3;
  logic        rd_ack = 1'b0;
  logic        stat_wr = 1'b0;
  logic [15:0] stat_wdata = 16'h0;
  logic [15:0] irq_mask = 16'h0;
  logic [7:0]  rx_data;
  logic        rx_valid, frame_err, parity_err, break_det, rx_timeout, irq_out;
  logic [15:0] irq_status;

  serial_rx_engine #(.OVERSAMPLE(OS)) i_serial_rx_engine (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rxd_in(rxd_in),
    .txd_in(txd_in), .txd_out(txd_out), .line_cfg(line_cfg), .rd_ack(rd_ack),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .irq_mask(irq_mask),
    .rx_data(rx_data), .rx_valid(rx_valid), .frame_err(frame_err),
    .parity_err(parity_err), .break_det(break_det), .rx_timeout(rx_timeout),
    .irq_status(irq_status), .irq_out(irq_out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  int cyc = 0, n_valid = 0, n_ferr = 0, n_perr = 0, n_brk = 0, n_tmo = 0;
  int t_valid = 0, t_tmo = 0;
  logic [7:0] last_byte = 8'h0;
  int m_valid, m_ferr, m_perr, m_brk, m_tmo;
  bit use_loop = 1'b0;
  bit done = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rx_valid) begin n_valid++; last_byte = rx_data; t_valid = cyc; end
    if (frame_err) n_ferr++;
    if (parity_err) n_perr++;
    if (break_det) n_brk++;
    if (rx_timeout) begin n_tmo++; t_tmo = cyc; end
  end

  task automatic mark();
    m_valid = n_valid; m_ferr = n_ferr; m_perr = n_perr; m_brk = n_brk; m_tmo = n_tmo;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cfg(input int len, input bit two, input logic [2:0] pf,
                                         input bit fbrk, input bit loop, input int tmo);
    return {tmo[15:0], 8'h00, loop, fbrk, pf, two, len[1:0]};
  endfunction

  function automatic logic par_of(input logic [2:0] pf, input logic [7:0] d);
    int ones = $countones(d);
    case (pf)
      3'b001:  return logic'(ones % 2);
      3'b011:  return logic'(1 - ones % 2);
      3'b101:  return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic put_bit(input logic v, input int n);
    if (use_loop) txd_in = v; else rxd_in = v;
    repeat (n) @(posedge clk);
    #1;
  endtask

  // start, data, optional parity (optionally flipped), stop bits, idle gap
  task automatic send(input logic [7:0] d, input int len, input bit two, input logic [2:0] pf,
                      input bit pflip, input logic s1, input logic s2, input int gap);
    int nb = len + 5;
    logic [7:0] dm = d & 8'((16'd1 << nb) - 1);
    put_bit(1'b0, OS);
    for (int i = 0; i < nb; i++) put_bit(d[i], OS);
    if (pf[0]) put_bit(par_of(pf, dm) ^ pflip, OS);
    put_bit(s1, OS);
    if (two) put_bit(s2, OS);
    put_bit(1'b1, gap);
  endtask

  task automatic clear_stat();
    stat_wr = 1'b1; stat_wdata = 16'hFFFF;
    @(posedge clk); #1;
    stat_wr = 1'b0; stat_wdata = 16'h0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual expired expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] pmodes [5] = '{3'b000, 3'b001, 3'b011, 3'b101, 3'b111};
    logic [7:0] pats [4] = '{8'h55, 8'hA3, 8'hFF, 8'h00};
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk("R11 status", int'(irq_status), 0);
    chk("R11 irq", int'(irq_out), 0);
    chk("R11 valid", int'(rx_valid), 0);
    chk("R11 txd", int'(txd_out), 1);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;

    // R1 R2 R3 sweep of lengths, stop counts and parity modes
    for (int len = 0; len < 4; len++)
      for (int two = 0; two < 2; two++)
        for (int p = 0; p < 5; p++)
          for (int k = 0; k < 4; k++) begin
            logic [7:0] expb;
            expb = pats[k] & 8'((16'd1 << (len + 5)) - 1);
            line_cfg = mk_cfg(len, two[0], pmodes[p], 1'b0, 1'b0, 0);
            mark();
            send(pats[k], len, two[0], pmodes[p], 1'b0, 1'b1, 1'b1, 4 * OS);
            chk("R1 count", n_valid - m_valid, 1);
            chk("R1 data", int'(last_byte), int'(expb));
            chk("R3 no perr", n_perr - m_perr, 0);
            chk("R2 no ferr", n_ferr - m_ferr, 0);
          end

    // R3 wrong parity bit in every parity mode
    for (int p = 1; p < 5; p++) begin
      line_cfg = mk_cfg(3, 1'b0, pmodes[p], 1'b0, 1'b0, 0);
      mark();
      send(8'h6C, 3, 1'b0, pmodes[p], 1'b1, 1'b1, 1'b1, 4 * OS);
      chk("R3 perr", n_perr - m_perr, 1);
      chk("R3 byte kept", int'(last_byte), 8'h6C);
    end

    // R4 low stop bit on a nonzero character
    line_cfg = mk_cfg(3, 1'b0, 3'b000, 1'b0, 1'b0, 0);
    clear_stat();
    mark();
    send(8'h3A, 3, 1'b0, 3'b000, 1'b0, 1'b0, 1'b1, 4 * OS);
    chk("R4 ferr", n_ferr - m_ferr, 1);
    chk("R4 valid", n_valid - m_valid, 1);
    chk("R4 byte", int'(last_byte), 8'h3A);
    chk("R9 frame bit", int'(irq_status), 1 << 10);

    // R2 second stop bit low
    line_cfg = mk_cfg(2, 1'b1, 3'b000, 1'b0, 1'b0, 0);
    mark();
    send(8'h11, 2, 1'b1, 3'b000, 1'b0, 1'b1, 1'b0, 4 * OS);
    chk("R2 ferr 2nd stop", n_ferr - m_ferr, 1);

    // R5 break: whole frame low
    line_cfg = mk_cfg(3, 1'b0, 3'b001, 1'b0, 1'b0, 0);
    clear_stat();
    mark();
    put_bit(1'b0, 14 * OS);
    put_bit(1'b1, 4 * OS);
    chk("R5 brk", n_brk - m_brk, 1);
    chk("R5 no valid", n_valid - m_valid, 0);
    chk("R5 no ferr", n_ferr - m_ferr, 0);
    chk("R9 break bit", int'(irq_status), 1 << 11);
    mark();
    send(8'h81, 3, 1'b0, 3'b001, 1'b0, 1'b1, 1'b1, 4 * OS);
    chk("R5 recovers", int'(last_byte), 8'h81);

    // R6 glitches at and below half a bit
    mark();
    put_bit(1'b0, OS / 2);
    put_bit(1'b1, 4 * OS);
    put_bit(1'b0, 3);
    put_bit(1'b1, 16 * OS);
    chk("R6 glitch", n_valid - m_valid + n_brk - m_brk, 0);

    // R9 R10 status clearing and masking
    clear_stat();
    mark();
    send(8'h0F, 3, 1'b0, 3'b001, 1'b1, 1'b1, 1'b1, 4 * OS);
    chk("R9 parity bit", int'(irq_status), 1 << 13);
    irq_mask = 16'h2000; #1;
    chk("R10 enabled", int'(irq_out), 1);
    irq_mask = 16'h0400; #1;
    chk("R10 masked", int'(irq_out), 0);
    stat_wr = 1'b1; stat_wdata = 16'h0400; @(posedge clk); #1; stat_wr = 1'b0;
    chk("R9 other bit kept", int'(irq_status), 1 << 13);
    stat_wr = 1'b1; stat_wdata = 16'h2000; @(posedge clk); #1; stat_wr = 1'b0;
    chk("R9 cleared", int'(irq_status), 0);
    irq_mask = 16'h0;

    // R8 timeout of 3 bit times
    line_cfg = mk_cfg(3, 1'b0, 3'b000, 1'b0, 1'b0, 3);
    mark();
    send(8'h42, 3, 1'b0, 3'b000, 1'b0, 1'b1, 1'b1, 8 * OS);
    chk("R8 once", n_tmo - m_tmo, 1);
    chk("R8 window", int'((t_tmo - t_valid) >= 3 * OS - 1 && (t_tmo - t_valid) <= 3 * OS + 3), 1);
    chk("R9 timeout bit", int'(irq_status[12]), 1);

    // R8 acknowledged before expiry
    line_cfg = mk_cfg(3, 1'b0, 3'b000, 1'b0, 1'b0, 8);
    mark();
    send(8'h43, 3, 1'b0, 3'b000, 1'b0, 1'b1, 1'b1, OS);
    rd_ack = 1'b1; @(posedge clk); #1; rd_ack = 1'b0;
    repeat (12 * OS) @(posedge clk);
    #1;
    chk("R8 ack cancels", n_tmo - m_tmo, 0);

    // R8 zero disables
    line_cfg = mk_cfg(3, 1'b0, 3'b000, 1'b0, 1'b0, 0);
    mark();
    send(8'h44, 3, 1'b0, 3'b000, 1'b0, 1'b1, 1'b1, 20 * OS);
    chk("R8 zero off", n_tmo - m_tmo, 0);

    // R8 back-to-back characters restart the count
    line_cfg = mk_cfg(3, 1'b0, 3'b000, 1'b0, 1'b0, 14);
    mark();
    send(8'h45, 3, 1'b0, 3'b000, 1'b0, 1'b1, 1'b1, OS);
    send(8'h46, 3, 1'b0, 3'b000, 1'b0, 1'b1, 1'b1, 20 * OS);
    chk("R8 restart once", n_tmo - m_tmo, 1);
    chk("R8 restart window", int'((t_tmo - t_valid) >= 14 * OS - 1 && (t_tmo - t_valid) <= 14 * OS + 3), 1);

    // R7 loopback ignores rxd_in
    line_cfg = mk_cfg(3, 1'b0, 3'b000, 1'b0, 1'b1, 0);
    @(posedge clk); #1;
    rxd_in = 1'b0;
    use_loop = 1'b1;
    mark();
    send(8'hC5, 3, 1'b0, 3'b000, 1'b0, 1'b1, 1'b1, 4 * OS);
    chk("R7 loopback", int'(last_byte), 8'hC5);
    chk("R7 loop count", n_valid - m_valid, 1);
    use_loop = 1'b0;
    rxd_in = 1'b1;
    @(posedge clk); #1;

    // R7 forced break on transmit line
    line_cfg = mk_cfg(3, 1'b0, 3'b000, 1'b1, 1'b0, 0);
    txd_in = 1'b1; #1;
    chk("R7 force low", int'(txd_out), 0);
    line_cfg = mk_cfg(3, 1'b0, 3'b000, 1'b0, 1'b0, 0); #1;
    chk("R7 follow", int'(txd_out), 1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule